// File: doc/BRIEF.md
# Simultaneous-Sampling Conversion Sequencer

This block is the digital timing controller for a dual-channel converter that samples both members of a matched channel pair at the same instant. A start request can come from any of four lines: two event triggers, a software trigger and an external start pin. When a request is accepted, the block latches the pair index, the acquisition width and the dual/single mode setting. It then drives the sample/hold pulse and the pair select for the analog mux. After the hold edge it captures the converter's A and B words into two result registers at fixed latencies and raises a sticky interrupt flag.

All timing runs on one clock at twice the converter clock rate, so one converter clock is two ticks. A request that arrives while a conversion is in progress is held as pending and started back to back: the next hold pulse rises two converter clocks after the previous falling edge. A further request that arrives while one is already pending sets a sticky overflow flag.

Top module: `adc_simul_seq`

## Requirements
- R1: `muxSel` holds the 3-bit pair index that was present when the current sample was started, selecting pair An/Bn with the same index n. It is 0 after reset.
- R2: A one-cycle high on any of `evTrigA`, `evTrigB`, `swTrig` or `extSoc` starts a conversion when the block is idle.
- R3: A request accepted in idle at clock edge k makes `shPulse` rise at edge k+5, which is 2.5 converter clocks.
- R4: `shPulse` stays high for 2*(1+acqWidth) ticks, that is 1 to 16 converter clocks, where acqWidth is the value latched at the start.
- R5: With F the edge at which `shPulse` falls, `resA` is loaded with `convA` at edge F+8 (4 converter clocks).
- R6: In dual mode (`dualMode`=1 latched at the start), `resB` is loaded with `convB` at edge F+10, one converter clock after A. In single mode `resB` is never written.
- R7: A pending request starts the next hold pulse 4 ticks after the falling edge, so successive samples are spaced 2*(3+acqWidth) ticks apart. A request during that 4-tick gap is served the same way.
- R8: `irqFlag` sets 2 ticks after the last result write of a sample (F+12 in dual mode, F+10 in single mode). It stays set until `flagClr` is high, and a new set wins over a clear in the same cycle.
- R9: A request that arrives while one is already pending and not being served sets `ovfFlag`. The flag is sticky until `flagClr`.
- R10: After synchronous reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the converter clock rate |
| rst | input | 1 | Synchronous active-high reset |
| evTrigA | input | 1 | Event trigger line A |
| evTrigB | input | 1 | Event trigger line B |
| swTrig | input | 1 | Software start request |
| extSoc | input | 1 | External start pin |
| pairIdx | input | 3 | Channel-pair index n for An/Bn |
| acqWidth | input | 4 | Acquisition width setting, 0 to 15 |
| dualMode | input | 1 | 1: convert both channels; 0: A only |
| convA | input | 12 | Converter output word for channel A |
| convB | input | 12 | Converter output word for channel B |
| flagClr | input | 1 | Write-one-to-clear for irqFlag and ovfFlag |
| shPulse | output | 1 | Sample/hold pulse |
| muxSel | output | 3 | Pair select to the analog mux |
| resA | output | 12 | Result register A |
| resB | output | 12 | Result register B |
| irqFlag | output | 1 | Conversion-complete flag |
| ovfFlag | output | 1 | Request overflow flag |

## Verification
A counter that loses a tick shifts the rise or fall of `shPulse` by one cycle. The fault is visible on the first sample after it occurs and affects every later result and interrupt time. A corrupted pending bit or latency pipeline either drops a back-to-back sample or writes `resA`/`resB` in the wrong cycle. A stale mode bit lets `resB` change in single mode. All of these show up at the ports within about twenty ticks of the hold edge. Because of this, the reference model is compared against every output on every cycle instead of only at the end of a run.

// File: rtl/adc_simul_seq_pkg.sv
package adc_simul_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DELAY, ST_HOLD, ST_GAP} seq_state_t;

  // One-cycle strobe from control to datapath at the hold falling edge
  typedef struct packed {
    logic fall;
    logic dual;
  } seq_stb_t;
endpackage

// File: rtl/adc_simul_seq_ctrl.sv
module adc_simul_seq_ctrl
  import adc_simul_seq_pkg::*;
#(
  parameter int PAIR_W    = 3,
  parameter int ACQ_W     = 4,
  parameter int START_DLY = 5,
  parameter int GAP_TICKS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig,
  input  logic [PAIR_W-1:0] pairIdx,
  input  logic [ACQ_W-1:0]  acqWidth,
  input  logic              dualMode,
  input  logic              flagClr,
  output logic              shPulse,
  output logic [PAIR_W-1:0] muxSel,
  output logic              ovfFlag,
  output seq_stb_t          stb
);
  localparam int CNT_W = ACQ_W + 2;

  seq_state_t state;
  logic [CNT_W-1:0] cnt;
  logic pend;
  logic [ACQ_W-1:0] cfgAcq;
  logic cfgDual;
  logic lastTick;
  logic ovfSet;

  // hold length in ticks: two per converter clock
  function automatic logic [CNT_W-1:0] holdLen(input logic [ACQ_W-1:0] acq);
    return {1'b0, acq, 1'b0} + CNT_W'(2);
  endfunction

  assign lastTick = (cnt == CNT_W'(1));
  assign shPulse  = (state == ST_HOLD);
  assign stb.fall = (state == ST_HOLD) && lastTick;
  assign stb.dual = cfgDual;
  // a request while one waits, except when the wait is being served now
  assign ovfSet   = trig && pend && (state != ST_IDLE) && !((state == ST_GAP) && lastTick);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      pend    <= 1'b0;
      cfgAcq  <= '0;
      cfgDual <= 1'b0;
      muxSel  <= '0;
      ovfFlag <= 1'b0;
    end else begin
      ovfFlag <= ovfSet || (ovfFlag && !flagClr);
      unique case (state)
        ST_IDLE: begin
          if (trig) begin
            state   <= ST_DELAY;
            cnt     <= CNT_W'(START_DLY);
            cfgAcq  <= acqWidth;
            cfgDual <= dualMode;
            muxSel  <= pairIdx;
          end
        end
        ST_DELAY, ST_HOLD: begin
          if (trig && !pend) pend <= 1'b1;
          if (!lastTick) begin
            cnt <= cnt - CNT_W'(1);
          end else if (state == ST_DELAY) begin
            state <= ST_HOLD;
            cnt   <= holdLen(cfgAcq);
          end else begin
            state <= ST_GAP;
            cnt   <= CNT_W'(GAP_TICKS);
          end
        end
        ST_GAP: begin
          if (!lastTick) begin
            cnt <= cnt - CNT_W'(1);
            if (trig && !pend) pend <= 1'b1;
          end else if (pend || trig) begin
            state   <= ST_HOLD;
            cnt     <= holdLen(acqWidth);
            cfgAcq  <= acqWidth;
            cfgDual <= dualMode;
            muxSel  <= pairIdx;
            pend    <= pend && trig;
          end else begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_simul_seq_dp.sv
module adc_simul_seq_dp
  import adc_simul_seq_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int A_LAT   = 8,
  parameter int B_LAT   = 10,
  parameter int IRQ_DLY = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_stb_t          stb,
  input  logic [DATA_W-1:0] convA,
  input  logic [DATA_W-1:0] convB,
  input  logic              flagClr,
  output logic [DATA_W-1:0] resA,
  output logic [DATA_W-1:0] resB,
  output logic              irqFlag
);
  localparam int PIPE_LEN = B_LAT + IRQ_DLY;
  localparam int A_TAP    = A_LAT - 1;
  localparam int B_TAP    = B_LAT - 1;
  localparam int IA_TAP   = A_LAT + IRQ_DLY - 1;
  localparam int IB_TAP   = PIPE_LEN - 1;

  logic [PIPE_LEN-1:0] hitPipe;
  logic [PIPE_LEN-1:0] dualPipe;
  logic irqSet;

  assign irqSet = (hitPipe[IB_TAP] && dualPipe[IB_TAP]) ||
                  (hitPipe[IA_TAP] && !dualPipe[IA_TAP]);

  always_ff @(posedge clk) begin
    if (rst) begin
      hitPipe  <= '0;
      dualPipe <= '0;
      resA     <= '0;
      resB     <= '0;
      irqFlag  <= 1'b0;
    end else begin
      hitPipe  <= {hitPipe[PIPE_LEN-2:0], stb.fall};
      dualPipe <= {dualPipe[PIPE_LEN-2:0], stb.dual};
      if (hitPipe[A_TAP]) resA <= convA;
      if (hitPipe[B_TAP] && dualPipe[B_TAP]) resB <= convB;
      irqFlag <= irqSet || (irqFlag && !flagClr);
    end
  end
endmodule

// File: rtl/adc_simul_seq.sv
module adc_simul_seq
  import adc_simul_seq_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int PAIR_W = 3,
  parameter int ACQ_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evTrigA,
  input  logic              evTrigB,
  input  logic              swTrig,
  input  logic              extSoc,
  input  logic [PAIR_W-1:0] pairIdx,
  input  logic [ACQ_W-1:0]  acqWidth,
  input  logic              dualMode,
  input  logic [DATA_W-1:0] convA,
  input  logic [DATA_W-1:0] convB,
  input  logic              flagClr,
  output logic              shPulse,
  output logic [PAIR_W-1:0] muxSel,
  output logic [DATA_W-1:0] resA,
  output logic [DATA_W-1:0] resB,
  output logic              irqFlag,
  output logic              ovfFlag
);
  seq_stb_t stb;
  logic trig;

  assign trig = evTrigA || evTrigB || swTrig || extSoc;

  adc_simul_seq_ctrl #(.PAIR_W(PAIR_W), .ACQ_W(ACQ_W)) u_ctrl (
    .clk(clk), .rst(rst), .trig(trig), .pairIdx(pairIdx), .acqWidth(acqWidth),
    .dualMode(dualMode), .flagClr(flagClr), .shPulse(shPulse), .muxSel(muxSel),
    .ovfFlag(ovfFlag), .stb(stb)
  );

  adc_simul_seq_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .convA(convA), .convB(convB),
    .flagClr(flagClr), .resA(resA), .resB(resB), .irqFlag(irqFlag)
  );
endmodule

// File: rtl/adc_simul_seq_chk.sv
module adc_simul_seq_chk #(
  parameter int DATA_W = 12,
  parameter int PAIR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              flagClr,
  input logic              shPulse,
  input logic [PAIR_W-1:0] muxSel,
  input logic [DATA_W-1:0] resA,
  input logic [DATA_W-1:0] resB,
  input logic              irqFlag,
  input logic              ovfFlag
);
  AST_MUX_HELD: assert property (@(posedge clk) disable iff (rst)
    (shPulse && $past(shPulse)) |-> $stable(muxSel)); // R1
  AST_HOLD_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(shPulse) |-> $past(shPulse, 2)); // R4
  AST_B_APART_FROM_A: assert property (@(posedge clk) disable iff (rst)
    !$stable(resB) |-> $stable(resA)); // R6
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irqFlag && !flagClr) |=> irqFlag); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovfFlag && !flagClr) |=> ovfFlag); // R9
endmodule

bind adc_simul_seq adc_simul_seq_chk #(.DATA_W(DATA_W), .PAIR_W(PAIR_W)) u_chk (
  .clk(clk), .rst(rst), .flagClr(flagClr), .shPulse(shPulse), .muxSel(muxSel),
  .resA(resA), .resB(resB), .irqFlag(irqFlag), .ovfFlag(ovfFlag)
);

// File: tb/adc_simul_seq_tb.sv
`timescale 1ns/1ps
module adc_simul_seq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evTrigA = 0, evTrigB = 0, swTrig = 0, extSoc = 0, dualMode = 0, flagClr = 0;
  logic [2:0] pairIdx = '0;
  logic [3:0] acqWidth = '0;
  logic [11:0] convA = '0, convB = '0;
  logic shPulse, irqFlag, ovfFlag;
  logic [2:0] muxSel;
  logic [11:0] resA, resB;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  adc_simul_seq u_dut (.*);

  // ---------------- behavioural reference model ----------------
  int n = 0;
  bit busyM = 0, pendM = 0, ovfM = 0, irqM = 0, dualM = 0;
  int riseT = 0, fallT = 0, gapEnd = 0;
  logic [2:0] muxM = '0;
  logic [11:0] resAM = '0, resBM = '0;
  int fallQ[$];
  bit dualQ[$];

  task automatic startAt(int t, int delay);
    riseT  = t + delay;
    fallT  = riseT + 2 * (acqWidth + 1);
    gapEnd = fallT + 4;
    muxM   = pairIdx;
    dualM  = dualMode;
    busyM  = 1;
  endtask

  always @(posedge clk) begin
    bit trigM, irqSet;
    n++;
    trigM = evTrigA | evTrigB | swTrig | extSoc;
    if (rst) begin
      busyM = 0; pendM = 0; ovfM = 0; irqM = 0; muxM = '0;
      resAM = '0; resBM = '0; fallQ.delete(); dualQ.delete();
    end else begin
      irqSet = 0;
      foreach (fallQ[i]) begin
        if (n == fallQ[i] + 8) resAM = convA;
        if (dualQ[i] && n == fallQ[i] + 10) resBM = convB;
        if ((dualQ[i] && n == fallQ[i] + 12) || (!dualQ[i] && n == fallQ[i] + 10)) irqSet = 1;
      end
      while (fallQ.size() > 0 && n >= fallQ[0] + 12) begin
        void'(fallQ.pop_front());
        void'(dualQ.pop_front());
      end
      irqM = irqSet | (irqM & !flagClr);
      if (busyM && n == fallT) begin
        fallQ.push_back(n);
        dualQ.push_back(dualM);
      end
      if (busyM && trigM && pendM && n != gapEnd) ovfM = 1;
      else if (flagClr) ovfM = 0;
      if (!busyM) begin
        if (trigM) startAt(n, 5);
      end else if (n == gapEnd) begin
        if (pendM) begin startAt(n, 0); pendM = trigM; end
        else if (trigM) startAt(n, 0);
        else busyM = 0;
      end else if (trigM) begin
        pendM = 1;
      end
    end
  end

  function automatic bit shExp();
    return busyM && (riseT <= n) && (n < fallT);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", req, what, cyc, act, exp);
    end
  endtask

  // compare on every cycle away from the active edge, then move data inputs
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk(shPulse == shExp(), "R3/R4/R7", "shPulse", shPulse, shExp());
      chk(muxSel == muxM, "R1", "muxSel", muxSel, muxM);
      chk(resA == resAM, "R5", "resA", resA, resAM);
      chk(resB == resBM, "R6", "resB", resB, resBM);
      chk(irqFlag == irqM, "R8", "irqFlag", irqFlag, irqM);
      chk(ovfFlag == ovfM, "R9", "ovfFlag", ovfFlag, ovfM);
    end
    convA <= 12'(cyc * 37 + 5);
    convB <= 12'(cyc * 91 + 1000);
  end

  task automatic waitCyc(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    case (which)
      0: evTrigA = 1;
      1: evTrigB = 1;
      2: swTrig  = 1;
      default: extSoc = 1;
    endcase
    @(negedge clk);
    evTrigA = 0; evTrigB = 0; swTrig = 0; extSoc = 0;
  endtask

  task automatic clearFlags();
    @(negedge clk); flagClr = 1;
    @(negedge clk); flagClr = 0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual=%0d expected=%0d", cyc, 0);
    finishRun();
  end

  initial begin
    waitCyc(4);
    // R10: reset state
    chk(!shPulse && muxSel == 0 && resA == 0 && resB == 0 && !irqFlag && !ovfFlag,
        "R10", "reset outputs", {shPulse, irqFlag, ovfFlag}, 0);
    rst = 0;
    waitCyc(3);
    // R2/R5/R6: event line A, dual mode, narrowest pulse, pair 3
    pairIdx = 3; acqWidth = 0; dualMode = 1;
    pulse(0); waitCyc(40);
    clearFlags();
    // R2/R6: event line B, single mode, resB must not move
    pairIdx = 7; acqWidth = 5; dualMode = 0;
    pulse(1); waitCyc(50);
    clearFlags();
    // R2/R4: software trigger, widest pulse, pair 0
    pairIdx = 0; acqWidth = 15; dualMode = 1;
    pulse(2); waitCyc(70);
    // R8: flag stays until cleared
    clearFlags(); waitCyc(5);
    // R7/R9: external start, a pending request, then an overflow
    pairIdx = 5; acqWidth = 2; dualMode = 1;
    pulse(3); waitCyc(5);
    pairIdx = 2;
    pulse(2); waitCyc(1);
    pulse(0); waitCyc(60);
    clearFlags(); waitCyc(4);
    // R7: request during the gap after the fall is served back to back
    pairIdx = 1; acqWidth = 0; dualMode = 1;
    pulse(1); waitCyc(7);
    pairIdx = 6; dualMode = 0;
    pulse(3); waitCyc(50);
    // R8: set and clear together, set wins
    pairIdx = 4; acqWidth = 1; dualMode = 1;
    pulse(0); waitCyc(17);
    flagClr = 1; waitCyc(4); flagClr = 0;
    waitCyc(20);
    finishRun();
  end
endmodule